// File: doc/BRIEF.md
# Programmable Down-Counter / Timer with Receive Timeout

This block is a 16-bit down-counter for a serial-port register map. Software programs a reload value as two byte writes and selects one of three modes. It starts and stops the count by reading two command addresses. Counting advances only on cycles where the external count-enable tick is high, so the clock-source logic stays outside the block.

In one-shot counter mode the count runs down from the reload value and raises a ready flag when it steps from 1 to 0. The count then wraps to all-ones and keeps going. In periodic timer mode the count reloads itself at every terminal count and produces a square wave. A stop command does not halt it. In receive-timeout mode, every character moved into the receive FIFO (a strobe input) reloads and restarts the count. The ready flag therefore marks a gap in the received data.

The ready flag drives an active-low interrupt through a mask bit. The block also has a waveform output that a select bit routes to an output pin.

Top module: `ct_timer`

## Requirements
- R1: After a synchronous reset, the count, status, mask and configuration registers all read 0, and the mode is counter mode. `irq_n` and `op_pin` are 1.
- R2: A read of address 0xE (start) loads the count from the reload value and starts counting. Writes to 0x6 and 0x7 set the reload upper and lower bytes. Reads of 0x6 and 0x7 return the count's upper and lower bytes. Read data appears one cycle after the read strobe.
- R3: A running count decrements by one only on cycles where `tick` is 1. With `tick` at 0, the count holds.
- R4: In counter mode (config bits[1:0] = 00 or 11), a tick at count 1 makes the count 0 and sets ready (status bit 3 at address 0x5). A tick at count 0 wraps the count to 0xFFFF and counting continues.
- R5: Writing the reload registers leaves a running count untouched. The new value is used from the next start onward.
- R6: A read of address 0xF (stop) clears ready. In counter and receive-timeout modes it also freezes the count.
- R7: In timer mode (config bits[1:0] = 01), a tick at count 1 loads the reload value and sets ready. A stop clears ready but does not halt the count.
- R8: In receive-timeout mode (config bits[1:0] = 10), an `rx_xfer` pulse loads the reload value and starts counting, and ready is set at the step 1 to 0. In the other modes `rx_xfer` has no effect.
- R9: `irq_n` is 0 exactly one cycle after ready and mask bit 3 (written at 0x5) are both 1, and is 1 otherwise.
- R10: A start drives the waveform to 0. At terminal count it goes to 1 in counter and receive-timeout modes and toggles in timer mode. `op_pin` shows the waveform one cycle later while config bit 2 is 1, and shows 1 otherwise.
- R11: A start, stop or receive reload in the same cycle as a tick takes priority, and that cycle's decrement is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tick | input | 1 | Count-enable tick |
| rx_xfer | input | 1 | Character moved into the receive FIFO |
| irq_n | output | 1 | Active-low interrupt request |
| op_pin | output | 1 | Routed waveform output |

## Verification
A wrong count shows up at the next read of address 0x6 or 0x7. A misplaced terminal count shows up one cycle later, as a wrong status bit, a wrong `irq_n` level or a wrong `op_pin` level. A wrongly cleared or stuck running flag shows as a count that changes, or fails to change, across a burst of ticks. The bench therefore checks every output and both count bytes after each action. It compares them against a per-tick model that is driven by the same actions.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic [1:0] {
    CT_COUNTER = 2'd0,
    CT_TIMER   = 2'd1,
    CT_RXTO    = 2'd2
  } ct_mode_e;

  localparam logic [3:0] A_CFG   = 4'h4;
  localparam logic [3:0] A_MASK  = 4'h5;
  localparam logic [3:0] A_HI    = 4'h6;
  localparam logic [3:0] A_LO    = 4'h7;
  localparam logic [3:0] A_START = 4'hE;
  localparam logic [3:0] A_STOP  = 4'hF;
  localparam int RDY_BIT = 3;
  localparam int CFG_W   = 3;
endpackage

// File: rtl/ct_regs.sv
module ct_regs
  import ct_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  reload,
  output ct_mode_e          mode,
  output logic              sel,
  output logic              mask,
  output logic              start,
  output logic              stop
);
  logic [CFG_W-1:0] cfg_q;

  assign start = rd_en && (addr == ADDR_W'(A_START));
  assign stop  = rd_en && (addr == ADDR_W'(A_STOP));
  assign sel   = cfg_q[2];

  always_comb begin
    case (cfg_q[1:0])
      2'd1:    mode = CT_TIMER;
      2'd2:    mode = CT_RXTO;
      default: mode = CT_COUNTER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= '0;
      cfg_q  <= '0;
      mask   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(A_HI):   reload[CNT_W-1:DATA_W] <= wdata;
        ADDR_W'(A_LO):   reload[DATA_W-1:0]     <= wdata;
        ADDR_W'(A_CFG):  cfg_q <= wdata[CFG_W-1:0];
        ADDR_W'(A_MASK): mask  <= wdata[RDY_BIT];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(A_CFG):  rdata <= DATA_W'(cfg_q);
        ADDR_W'(A_MASK): rdata <= DATA_W'(ready) << RDY_BIT;
        ADDR_W'(A_HI):   rdata <= count[CNT_W-1:DATA_W];
        ADDR_W'(A_LO):   rdata <= count[DATA_W-1:0];
        default:         rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ct_core.sv
module ct_core
  import ct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rx_xfer,
  input  logic             start,
  input  logic             stop,
  input  ct_mode_e         mode,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             ready,
  output logic             wave
);
  logic rx_ld;
  logic at_one;

  assign rx_ld  = rx_xfer && (mode == CT_RXTO);
  assign at_one = (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
      ready   <= 1'b0;
      wave    <= 1'b1;
    end else if (start) begin
      count   <= reload;
      running <= 1'b1;
      wave    <= 1'b0;
    end else if (stop) begin
      ready <= 1'b0;
      if (mode != CT_TIMER) running <= 1'b0;
    end else if (rx_ld) begin
      count   <= reload;
      running <= 1'b1;
    end else if (running && tick) begin
      if (at_one) begin
        ready <= 1'b1;
        if (mode == CT_TIMER) begin
          count <= reload;
          wave  <= ~wave;
        end else begin
          count <= '0;
          wave  <= 1'b1;
        end
      end else begin
        count <= count - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ct_out.sv
module ct_out (
  input  logic clk,
  input  logic rst,
  input  logic ready,
  input  logic mask,
  input  logic wave,
  input  logic sel,
  output logic irq_n,
  output logic op_pin
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n  <= 1'b1;
      op_pin <= 1'b1;
    end else begin
      irq_n  <= ~(ready & mask);
      op_pin <= sel ? wave : 1'b1;
    end
  end
endmodule

// File: rtl/ct_timer.sv
module ct_timer
  import ct_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tick,
  input  logic              rx_xfer,
  output logic              irq_n,
  output logic              op_pin
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reload;
  ct_mode_e         mode;
  logic             sel, mask, start, stop, running, ready, wave;

  ct_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .count(count), .ready(ready), .rdata(rdata),
    .reload(reload), .mode(mode), .sel(sel), .mask(mask),
    .start(start), .stop(stop)
  );

  ct_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .rx_xfer(rx_xfer), .start(start),
    .stop(stop), .mode(mode), .reload(reload), .count(count),
    .running(running), .ready(ready), .wave(wave)
  );

  ct_out u_out (
    .clk(clk), .rst(rst), .ready(ready), .mask(mask), .wave(wave),
    .sel(sel), .irq_n(irq_n), .op_pin(op_pin)
  );
endmodule

// File: rtl/ct_timer_chk.sv
module ct_timer_chk #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              tick,
  input logic              rx_xfer,
  input logic [1:0]        mode,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              running,
  input logic              ready,
  input logic              mask,
  input logic              wave,
  input logic              sel,
  input logic              irq_n,
  input logic              op_pin
);
  logic st_rd, sp_rd, rx_go;
  assign st_rd = rd_en && (addr == ADDR_W'(4'hE));
  assign sp_rd = rd_en && (addr == ADDR_W'(4'hF));
  assign rx_go = rx_xfer && (mode == 2'd2);

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !st_rd && !rx_go) |=> $stable(count));

  a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
    st_rd |=> (count == $past(reload)) && running);

  a_r6_stop_clears: assert property (@(posedge clk) disable iff (rst)
    sp_rd |=> !ready);

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (running && tick && count == '0 && !st_rd && !sp_rd && !rx_go)
      |=> (count == '1));

  a_r9_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == !($past(ready) && $past(mask))));

  a_r10_pin: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (op_pin == ($past(sel) ? $past(wave) : 1'b1)));

  a_r11_start_wins: assert property (@(posedge clk) disable iff (rst)
    (st_rd && tick) |=> (count == $past(reload)));
endmodule

bind ct_timer ct_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .tick(tick),
  .rx_xfer(rx_xfer), .mode(mode), .count(count), .reload(reload),
  .running(running), .ready(ready), .mask(mask), .wave(wave), .sel(sel),
  .irq_n(irq_n), .op_pin(op_pin)
);

// File: tb/ct_timer_tb.sv
module ct_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 1'b0, wr_en = 1'b0, tick = 1'b0, rx_xfer = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n, op_pin;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  // Model state
  logic [15:0] m_cnt = '0, m_rel = '0;
  logic [2:0]  m_cfg = '0;
  logic        m_run = 0, m_rdy = 0, m_wave = 1, m_mask = 0;

  always #5 clk = ~clk;

  ct_timer u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick), .rx_xfer(rx_xfer),
    .irq_n(irq_n), .op_pin(op_pin)
  );

  function automatic logic [1:0] m_mode();
    if (m_cfg[1:0] == 2'd1) return 2'd1;
    if (m_cfg[1:0] == 2'd2) return 2'd2;
    return 2'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    case (a)
      4'h6: m_rel[15:8] = d;
      4'h7: m_rel[7:0]  = d;
      4'h4: m_cfg = d[2:0];
      4'h5: m_mask = d[3];
      default: ;
    endcase
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    d = rdata;
  endtask

  task automatic do_start();
    logic [7:0] d;
    rd(4'hE, d);
    m_cnt = m_rel; m_run = 1; m_wave = 0;
  endtask

  task automatic do_stop();
    logic [7:0] d;
    rd(4'hF, d);
    m_rdy = 0;
    if (m_mode() != 2'd1) m_run = 0;
  endtask

  task automatic do_rx();
    @(negedge clk); rx_xfer = 1;
    @(negedge clk); rx_xfer = 0;
    if (m_mode() == 2'd2) begin m_cnt = m_rel; m_run = 1; end
  endtask

  task automatic model_tick();
    if (m_run) begin
      if (m_cnt == 16'd1) begin
        m_rdy = 1;
        if (m_mode() == 2'd1) begin m_cnt = m_rel; m_wave = ~m_wave; end
        else begin m_cnt = 16'd0; m_wave = 1; end
      end else m_cnt = m_cnt - 16'd1;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      model_tick();
    end
    if (n > 0) begin @(negedge clk); tick = 0; end
  endtask

  task automatic check_all(string req);
    logic [7:0] hi, lo, st;
    @(negedge clk);
    chk({req, " irq_n"}, irq_n, !(m_rdy && m_mask));
    chk({req, " op_pin"}, op_pin, m_cfg[2] ? m_wave : 1'b1);
    rd(4'h6, hi);
    rd(4'h7, lo);
    rd(4'h5, st);
    chk({req, " count"}, {hi, lo}, m_cnt);
    chk({req, " status"}, st, {4'b0, m_rdy, 3'b0});
  endtask

  task automatic set_reload(logic [15:0] v);
    wr(4'h6, v[15:8]);
    wr(4'h7, v[7:0]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq_n", irq_n, 1'b1);
    chk("R1 op_pin", op_pin, 1'b1);
    rd(4'h4, d); chk("R1 cfg", d, 8'h00);
    check_all("R1");

    // R2 start load, R3 hold, R4 terminal and wrap
    set_reload(16'h0005);
    check_all("R2 before start");
    do_start();
    check_all("R2 start");
    repeat (4) @(negedge clk);
    check_all("R3 idle hold");
    ticks(4); check_all("R3 four ticks");
    ticks(1); check_all("R4 terminal");
    wr(4'h5, 8'h08); check_all("R9 irq");
    ticks(1); check_all("R4 wrap");
    ticks(2); check_all("R4 after wrap");
    do_stop(); check_all("R6 stop");
    ticks(3); check_all("R6 frozen");

    // R5 reload write while running
    set_reload(16'h1234); do_start();
    set_reload(16'h0003);
    ticks(2); check_all("R5 unaffected");
    do_start(); check_all("R5 new value");

    // R10 routed waveform, counter mode
    wr(4'h4, 8'h04); do_start(); check_all("R10 start low");
    ticks(3); check_all("R10 terminal high");

    // R7 timer mode
    wr(4'h4, 8'h05); do_start();
    ticks(3); check_all("R7 reload at terminal");
    do_stop(); check_all("R7 stop clears ready");
    ticks(3); check_all("R7 keeps running");
    ticks(2); check_all("R7 mid period");

    // R8 receive timeout
    wr(4'h4, 8'h02); do_stop(); set_reload(16'h0004);
    do_rx(); check_all("R8 rx load");
    ticks(2); check_all("R8 counting");
    do_rx(); check_all("R8 rx restart");
    ticks(4); check_all("R8 timeout");
    wr(4'h4, 8'h00); do_stop(); set_reload(16'h0009);
    do_rx(); check_all("R8 ignored in counter mode");
    ticks(2); check_all("R8 still stopped");

    // R11 start with tick in same cycle
    set_reload(16'h0020);
    @(negedge clk); rd_en = 1; addr = 4'hE; tick = 1;
    @(negedge clk); rd_en = 0; tick = 0;
    m_cnt = m_rel; m_run = 1; m_wave = 0;
    check_all("R11 start wins");

    // Random mix
    for (int it = 0; it < 80; it++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0: set_reload(($urandom % 3 == 0) ? 16'($urandom % 65535 + 1)
                                          : 16'($urandom % 8 + 1));
        1: do_start();
        2: do_stop();
        3: ticks(int'($urandom % 12));
        4: wr(4'h4, 8'($urandom % 8));
        5: do_rx();
        6: wr(4'h5, ($urandom % 2) ? 8'h08 : 8'h00);
        default: ticks(int'($urandom % 4));
      endcase
      check_all("R3 R4 R7 R8 R9 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule